// File: doc/BRIEF.md
# Decision Tree Packet Classifier

This block assigns a class, used as an output port number, to a packet from header feature values that have already been extracted. The trained tree is not built as one stage per tree level. Each feature has its own range table instead. That table converts the feature value into a short code word naming the interval the value falls in. A single exact-match decision table then takes all the code words together and returns the leaf class. A new model that uses the same features is loaded through the table write port, and the logic does not change.

The pipeline accepts one feature vector per clock. The range lookups of all features run in parallel in the first cycle. The decision lookup runs in the second cycle, and its result is registered as the output. Table writes may arrive at any time, including while traffic is flowing. A given vector always sees either the tables as they were before a write, or the tables as they are after it, and never a mixture.

Top module: `dtree_classifier`

## Requirements
- R1: `out_valid` rises exactly two clock edges after the edge that samples `in_valid` high, and stays low two edges after a cycle with `in_valid` low. One vector is accepted on every clock.
- R2: A range entry matches when it is valid and low <= value <= high, with both bounds inclusive. A matching entry supplies its code word for that feature.
- R3: When several valid entries of a feature match, the entry with the lowest index wins.
- R4: A feature value that matches no valid entry yields the reserved code 7 (all ones). This code takes part in the decision key like any other code.
- R5: The decision key is the concatenation of the codes, with feature 0 in bits [2:0], feature 1 in bits [5:3], and so on. The valid decision entry with the lowest index whose key equals this key gives `out_class`.
- R6: When no decision entry matches, `out_class` is the programmed default class.
- R7: A write with `cfg_table` = f < 5 loads range entry `cfg_index` of feature f from `cfg_wdata` = {valid[35], code[34:32], high[31:16], low[15:0]}. `cfg_table` = 5 loads decision entry `cfg_index` as {valid[18], class[17:15], key[14:0]}. `cfg_table` = 6 sets the default class from bits [2:0]. Writing valid = 0 removes an entry.
- R8: A vector presented in the same cycle as a write is classified entirely with the old contents. A vector presented in any later cycle is classified entirely with the new contents.
- R9: After reset, `out_valid` and `out_class` are 0, every entry is invalid and the default class is 0, so every vector is classified as class 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Feature vector valid |
| in_feat | input | 80 | Five 16-bit features, feature 0 in bits [15:0] |
| cfg_we | input | 1 | Table write strobe |
| cfg_table | input | 3 | Target: 0-4 range table, 5 decision table, 6 default class |
| cfg_index | input | 5 | Entry index within the target table |
| cfg_wdata | input | 36 | Entry contents, with the field layout given in R7 |
| out_valid | output | 1 | Class result valid |
| out_class | output | 3 | Leaf class, used as the output port assignment |

## Verification
The assertions assume that `cfg_table` never names a target above 6 while `cfg_we` is high. They also assume that `in_valid` is driven low throughout reset, so the valid pipeline starts empty. The stimulus only writes targets 0 to 6, holds `in_valid` low during reset, and drives every input at the falling edge. Random writes are mixed into back-to-back traffic, and the model applies each write only after classifying the vector of the same cycle. The tables the model builds may overlap, lack entries or hold the reserved code, and the decision key is still formed correctly.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int DTC_NUM_FEAT    = 5;
  localparam int DTC_FEAT_W      = 16;
  localparam int DTC_RANGE_DEPTH = 8;
  localparam int DTC_CODE_W      = 3;
  localparam int DTC_DEC_DEPTH   = 32;
  localparam int DTC_CLASS_W     = 3;

  function automatic int dtc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dtc_range_stage.sv
module dtc_range_stage
  import dtc_pkg::*;
#(
  parameter int FEAT_W = DTC_FEAT_W,
  parameter int DEPTH  = DTC_RANGE_DEPTH,
  parameter int CODE_W = DTC_CODE_W,
  parameter int IDX_W  = 5,
  localparam int RIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [CODE_W-1:0] MISS_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FEAT_W-1:0] wr_lo,
  input  logic [FEAT_W-1:0] wr_hi,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_valid,
  input  logic [FEAT_W-1:0] feat,
  output logic [CODE_W-1:0] code_q
);

  logic [FEAT_W-1:0] lo_mem   [DEPTH];
  logic [FEAT_W-1:0] hi_mem   [DEPTH];
  logic [CODE_W-1:0] code_mem [DEPTH];
  logic [DEPTH-1:0]  ent_v;
  logic [DEPTH-1:0]  hit_vec;
  logic [CODE_W-1:0] sel_code;
  logic              idx_ok;

  assign idx_ok = (32'(wr_idx) < DEPTH);

  // entry storage: written one entry at a time from the config port
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lo_mem[i]   <= '0;
        hi_mem[i]   <= '0;
        code_mem[i] <= '0;
      end
    end else if (wr_en && idx_ok) begin
      lo_mem[wr_idx[RIDX_W-1:0]]   <= wr_lo;
      hi_mem[wr_idx[RIDX_W-1:0]]   <= wr_hi;
      code_mem[wr_idx[RIDX_W-1:0]] <= wr_code;
      ent_v[wr_idx[RIDX_W-1:0]]    <= wr_valid;
    end
  end

  // every entry compared in parallel, inclusive bounds
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = ent_v[g] && (feat >= lo_mem[g]) && (feat <= hi_mem[g]);
    end
  endgenerate

  // priority: lowest index wins, scan from the top so low indices override
  always_comb begin
    sel_code = MISS_CODE;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_code = code_mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= MISS_CODE;
    else     code_q <= sel_code;
  end

  // a code other than the miss code needs some valid entry in the table it came from
  assert_code_needs_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (code_q != MISS_CODE) |-> $past(|ent_v));

  // a hit registered on this edge must come from a valid entry
  assert_hit_from_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_vec & ~ent_v) == '0);

endmodule

// File: rtl/dtc_decision_stage.sv
module dtc_decision_stage
  import dtc_pkg::*;
#(
  parameter int KEY_W   = DTC_NUM_FEAT * DTC_CODE_W,
  parameter int DEPTH   = DTC_DEC_DEPTH,
  parameter int CLASS_W = DTC_CLASS_W,
  parameter int IDX_W   = 5,
  localparam int DIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [CLASS_W-1:0] wr_class,
  input  logic               wr_valid,
  input  logic               def_we,
  input  logic [CLASS_W-1:0] def_class,
  input  logic [KEY_W-1:0]   key,
  input  logic               key_valid,
  output logic               res_valid,
  output logic [CLASS_W-1:0] res_class
);

  // writes are held one cycle so that a vector already past the range
  // stage still decodes against the table it was matched with
  logic               pend_we;
  logic [DIDX_W-1:0]  pend_idx;
  logic [KEY_W-1:0]   pend_key;
  logic [CLASS_W-1:0] pend_class;
  logic               pend_valid;
  logic               pend_def_we;
  logic [CLASS_W-1:0] pend_def;

  logic [KEY_W-1:0]   key_mem [DEPTH];
  logic [CLASS_W-1:0] cls_mem [DEPTH];
  logic [DEPTH-1:0]   ent_v;
  logic [CLASS_W-1:0] def_q;
  logic [DEPTH-1:0]   hit_vec;
  logic [CLASS_W-1:0] sel_class;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_we     <= 1'b0;
      pend_idx    <= '0;
      pend_key    <= '0;
      pend_class  <= '0;
      pend_valid  <= 1'b0;
      pend_def_we <= 1'b0;
      pend_def    <= '0;
    end else begin
      pend_we     <= wr_en && (32'(wr_idx) < DEPTH);
      pend_idx    <= wr_idx[DIDX_W-1:0];
      pend_key    <= wr_key;
      pend_class  <= wr_class;
      pend_valid  <= wr_valid;
      pend_def_we <= def_we;
      pend_def    <= def_class;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      def_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_mem[i] <= '0;
        cls_mem[i] <= '0;
      end
    end else begin
      if (pend_we) begin
        key_mem[pend_idx] <= pend_key;
        cls_mem[pend_idx] <= pend_class;
        ent_v[pend_idx]   <= pend_valid;
      end
      if (pend_def_we) def_q <= pend_def;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = ent_v[g] && (key_mem[g] == key);
    end
  endgenerate

  always_comb begin
    sel_class = def_q;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_class = cls_mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_class <= '0;
    end else begin
      res_valid <= key_valid;
      if (key_valid) res_class <= sel_class;
    end
  end

  // a result that differs from the default needs a valid decision entry
  assert_class_needs_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(key_valid) && (res_class != $past(def_q))) |-> $past(|ent_v));

  // a held write always lands on the edge after it was captured
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    pend_we |=> (ent_v[$past(pend_idx)] == $past(pend_valid)));

endmodule

// File: rtl/dtree_classifier.sv
module dtree_classifier
  import dtc_pkg::*;
#(
  parameter int NUM_FEAT    = DTC_NUM_FEAT,
  parameter int FEAT_W      = DTC_FEAT_W,
  parameter int RANGE_DEPTH = DTC_RANGE_DEPTH,
  parameter int CODE_W      = DTC_CODE_W,
  parameter int DEC_DEPTH   = DTC_DEC_DEPTH,
  parameter int CLASS_W     = DTC_CLASS_W,
  localparam int KEY_W      = NUM_FEAT * CODE_W,
  localparam int TBL_W      = $clog2(NUM_FEAT + 2),
  localparam int IDX_W      = dtc_max($clog2(RANGE_DEPTH), $clog2(DEC_DEPTH)),
  localparam int RNG_DATA_W = 2 * FEAT_W + CODE_W + 1,
  localparam int DEC_DATA_W = KEY_W + CLASS_W + 1,
  localparam int WDATA_W    = dtc_max(RNG_DATA_W, DEC_DATA_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_FEAT*FEAT_W-1:0] in_feat,
  input  logic                       cfg_we,
  input  logic [TBL_W-1:0]           cfg_table,
  input  logic [IDX_W-1:0]           cfg_index,
  input  logic [WDATA_W-1:0]         cfg_wdata,
  output logic                       out_valid,
  output logic [CLASS_W-1:0]         out_class
);

  localparam logic [TBL_W-1:0] TBL_DEC = TBL_W'(NUM_FEAT);
  localparam logic [TBL_W-1:0] TBL_DEF = TBL_W'(NUM_FEAT + 1);

  logic [KEY_W-1:0] key_bus;
  logic             key_valid;

  // range write fields
  logic [FEAT_W-1:0] w_lo, w_hi;
  logic [CODE_W-1:0] w_code;
  logic              w_rvalid;

  assign w_lo     = cfg_wdata[FEAT_W-1:0];
  assign w_hi     = cfg_wdata[2*FEAT_W-1:FEAT_W];
  assign w_code   = cfg_wdata[2*FEAT_W+CODE_W-1:2*FEAT_W];
  assign w_rvalid = cfg_wdata[2*FEAT_W+CODE_W];

  genvar f;
  generate
    for (f = 0; f < NUM_FEAT; f++) begin : g_feat
      logic sel;
      assign sel = cfg_we && (cfg_table == TBL_W'(f));
      dtc_range_stage #(
        .FEAT_W (FEAT_W),
        .DEPTH  (RANGE_DEPTH),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
      ) u_range (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sel),
        .wr_idx   (cfg_index),
        .wr_lo    (w_lo),
        .wr_hi    (w_hi),
        .wr_code  (w_code),
        .wr_valid (w_rvalid),
        .feat     (in_feat[f*FEAT_W +: FEAT_W]),
        .code_q   (key_bus[f*CODE_W +: CODE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) key_valid <= 1'b0;
    else     key_valid <= in_valid;
  end

  dtc_decision_stage #(
    .KEY_W   (KEY_W),
    .DEPTH   (DEC_DEPTH),
    .CLASS_W (CLASS_W),
    .IDX_W   (IDX_W)
  ) u_decide (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we && (cfg_table == TBL_DEC)),
    .wr_idx    (cfg_index),
    .wr_key    (cfg_wdata[KEY_W-1:0]),
    .wr_class  (cfg_wdata[KEY_W+CLASS_W-1:KEY_W]),
    .wr_valid  (cfg_wdata[KEY_W+CLASS_W]),
    .def_we    (cfg_we && (cfg_table == TBL_DEF)),
    .def_class (cfg_wdata[CLASS_W-1:0]),
    .key       (key_bus),
    .key_valid (key_valid),
    .res_valid (out_valid),
    .res_class (out_class)
  );

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  assert_cfg_target_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (cfg_table <= TBL_DEF));

endmodule

// File: tb/dtree_classifier_bench.sv
module dtree_classifier_bench;

  localparam int NF = 5;
  localparam int FW = 16;
  localparam int RD = 8;
  localparam int DD = 32;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [79:0]   in_feat;
  logic          cfg_we;
  logic [2:0]    cfg_table;
  logic [4:0]    cfg_index;
  logic [35:0]   cfg_wdata;
  logic          out_valid;
  logic [2:0]    out_class;

  always #2 clk = ~clk;

  dtree_classifier u_dtree_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_feat(in_feat),
    .cfg_we(cfg_we), .cfg_table(cfg_table), .cfg_index(cfg_index),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_class(out_class)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model of the tables
  int m_lo [NF][RD];
  int m_hi [NF][RD];
  int m_cd [NF][RD];
  bit m_rv [NF][RD];
  int m_key [DD];
  int m_cls [DD];
  bit m_dv  [DD];
  int m_def;

  // two-slot expectation delay line
  bit    pv [2];
  int    pc [2];
  string pr [2];

  function automatic int model_code(int f, int v);
    for (int i = 0; i < RD; i++)
      if (m_rv[f][i] && v >= m_lo[f][i] && v <= m_hi[f][i]) return m_cd[f][i];
    return 7;
  endfunction

  function automatic int model_class(logic [79:0] fv);
    int k = 0;
    for (int f = 0; f < NF; f++)
      k = k | (model_code(f, int'(fv[f*FW +: FW])) << (CW * f));
    for (int i = 0; i < DD; i++)
      if (m_dv[i] && m_key[i] == k) return m_cls[i];
    return m_def;
  endfunction

  function automatic void model_write(int tbl, int idx, logic [35:0] d);
    if (tbl < NF) begin
      m_lo[tbl][idx] = int'(d[15:0]);
      m_hi[tbl][idx] = int'(d[31:16]);
      m_cd[tbl][idx] = int'(d[34:32]);
      m_rv[tbl][idx] = d[35];
    end else if (tbl == NF) begin
      m_key[idx] = int'(d[14:0]);
      m_cls[idx] = int'(d[17:15]);
      m_dv[idx]  = d[18];
    end else begin
      m_def = int'(d[2:0]);
    end
  endfunction

  function automatic logic [35:0] rw(int lo, int hi, int code, bit v);
    return {v, 3'(code), 16'(hi), 16'(lo)};
  endfunction

  function automatic logic [35:0] dw(int key, int cls, bit v);
    return {17'd0, v, 3'(cls), 15'(key)};
  endfunction

  function automatic logic [79:0] vec(int a, int b, int c, int d, int e);
    return {16'(e), 16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic step(input bit v, input logic [79:0] fv, input bit we,
                      input int tbl, input int idx, input logic [35:0] d,
                      input string req);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== pv[1]) begin
      n_bad++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, pv[1]);
    end else if (pv[1] && out_class !== 3'(pc[1])) begin
      n_bad++;
      $display("FAIL %s out_class actual %0d expected %0d", pr[1], out_class, pc[1]);
    end
    pv[1] = pv[0]; pc[1] = pc[0]; pr[1] = pr[0];
    pv[0] = v;
    pc[0] = v ? model_class(fv) : 0;
    pr[0] = req;
    if (we) model_write(tbl, idx, d);
    in_valid  = v;
    in_feat   = fv;
    cfg_we    = we;
    cfg_table = 3'(tbl);
    cfg_index = 5'(idx);
    cfg_wdata = d;
  endtask

  task automatic wr(int tbl, int idx, logic [35:0] d, string req);
    step(1'b0, '0, 1'b1, tbl, idx, d, req);
  endtask

  task automatic cls(logic [79:0] fv, string req);
    step(1'b1, fv, 1'b0, 0, 0, '0, req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0, 0, '0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < RD; i++) begin
        m_lo[f][i] = 0; m_hi[f][i] = 0; m_cd[f][i] = 0; m_rv[f][i] = 0;
      end
    for (int i = 0; i < DD; i++) begin
      m_key[i] = 0; m_cls[i] = 0; m_dv[i] = 0;
    end
    m_def = 0;
    pv[0] = 0; pv[1] = 0; pc[0] = 0; pc[1] = 0; pr[0] = "R1"; pr[1] = "R1";
    rst = 1'b1; in_valid = 0; in_feat = '0; cfg_we = 0;
    cfg_table = '0; cfg_index = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9: reset state at the ports
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_class !== 3'd0) begin
      n_bad++;
      $display("FAIL R9 reset outputs actual %0b/%0d expected 0/0", out_valid, out_class);
    end
    cls(vec(1, 2, 3, 4, 5), "R9");
    cls(vec(60000, 0, 0, 0, 0), "R9");
    idle(2);

    // R7: program three intervals per feature
    for (int f = 0; f < NF; f++) begin
      wr(f, 0, rw(0, 9, 0, 1), "R7");
      wr(f, 1, rw(10, 19, 1, 1), "R7");
      wr(f, 2, rw(20, 29, 2, 1), "R7");
    end
    wr(NF, 0, dw(0, 1, 1), "R7");
    wr(NF, 1, dw(1, 2, 1), "R7");
    wr(NF, 2, dw(7, 3, 1), "R7");
    wr(NF + 1, 0, 36'd4, "R7");
    idle(2);

    // R5: key decode, feature 0 in the low bits
    cls(vec(5, 5, 5, 5, 5), "R5");
    cls(vec(12, 3, 3, 3, 3), "R5");
    // R2: inclusive bounds
    cls(vec(9, 0, 9, 0, 9), "R2");
    cls(vec(10, 0, 0, 0, 0), "R2");
    cls(vec(19, 0, 0, 0, 0), "R2");
    // R4: miss code 7 in feature 0 field
    cls(vec(30, 0, 0, 0, 0), "R4");
    cls(vec(65535, 1, 2, 3, 4), "R4");
    // R6: no decision match
    cls(vec(0, 30, 0, 0, 0), "R6");
    cls(vec(25, 25, 25, 25, 25), "R6");
    idle(2);

    // R3: overlapping entries, lowest index wins
    wr(0, 3, rw(5, 14, 5, 1), "R3");
    wr(0, 4, rw(0, 100, 6, 1), "R3");
    wr(NF, 3, dw(5, 5, 1), "R3");
    wr(NF, 4, dw(6, 6, 1), "R3");
    idle(2);
    cls(vec(7, 0, 0, 0, 0), "R3");
    cls(vec(50, 0, 0, 0, 0), "R3");
    wr(0, 0, rw(0, 9, 0, 0), "R7");
    idle(2);
    cls(vec(7, 0, 0, 0, 0), "R3");
    cls(vec(2, 0, 0, 0, 0), "R3");
    idle(2);

    // R8: writes in the middle of back-to-back traffic
    step(1'b1, vec(7, 0, 0, 0, 0), 1'b1, NF, 3, dw(5, 2, 1), "R8");
    step(1'b1, vec(7, 0, 0, 0, 0), 1'b1, 0, 3, rw(5, 14, 1, 1), "R8");
    step(1'b1, vec(7, 0, 0, 0, 0), 1'b1, NF + 1, 0, 36'd6, "R8");
    step(1'b1, vec(40, 40, 0, 0, 0), 1'b1, NF, 1, dw(1, 0, 0), "R8");
    step(1'b1, vec(12, 0, 0, 0, 0), 1'b0, 0, 0, '0, "R8");
    idle(2);

    // R1 R8: random traffic with random writes
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom_range(0, 3) != 0);
      bit w = ($urandom_range(0, 5) == 0);
      int t = $urandom_range(0, NF + 1);
      logic [79:0] fv;
      logic [35:0] d;
      for (int f = 0; f < NF; f++) fv[f*FW +: FW] = 16'($urandom_range(0, 40));
      if (t < NF) begin
        int lo = $urandom_range(0, 35);
        d = rw(lo, lo + $urandom_range(0, 12), $urandom_range(0, 7), $urandom_range(0, 3) != 0);
        step(v, fv, w, t, $urandom_range(0, RD - 1), d, "R1 R8");
      end else if (t == NF) begin
        d = dw($urandom_range(0, 32767) & 15'h0249, $urandom_range(0, 7), 1'b1);
        step(v, fv, w, t, $urandom_range(0, DD - 1), d, "R5 R8");
      end else begin
        step(v, fv, w, t, 0, 36'($urandom_range(0, 7)), "R6 R8");
      end
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule